// File: doc/BRIEF.md
# BCD Alarm Comparator With Repeat Masks

This block keeps four alarm settings (second, minute, hour and day of month), each one byte wide and held in BCD. Once every second it compares them with the current calendar time, and when they agree it raises an interrupt and sets a readable alarm flag. The time-of-day counter is outside the block. That counter supplies the current second, minute, hour and date as BCD bytes, together with a tick that rises once per second.

Bit 7 of each alarm byte is a repeat mask. The mask bits on the date, hour, minute and second fields pick one of five repeat rates: monthly, daily, hourly, once a minute, or every second. Software reaches the alarm bytes and a status byte through a small byte-wide register port. A write with an out-of-range BCD value is dropped. Reading the status byte returns the alarm flag and clears it.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: Register slots are 0 = second, 1 = minute, 2 = hour, 3 = date and 4 = status, where status bit 7 is the alarm flag and the other status bits read 0. Every other slot reads 0xFF. An accepted write stores the whole byte, mask bit included, and that byte reads back unchanged.
- R2: A write is accepted only if the low BCD digit is 0–9 and the decoded value is in range. For second and minute the value comes from bits 6:0 and must be 0–59. For hour it comes from bits 5:0 and must be 0–23. For date it comes from bits 5:0 and must be 1–31. A rejected write leaves the stored byte unchanged.
- R3: With no mask bit set, the alarm fires only when all four fields match. Second and minute compare bits 6:0, and hour and date compare bits 5:0, on both the alarm side and the current-time side.
- R4: With only the date mask set, the alarm fires when hour, minute and second match, whatever the date.
- R5: With exactly the date and hour masks set, the alarm fires when minute and second match.
- R6: With the date, hour and minute masks set and the second mask clear, the alarm fires when the second matches.
- R7: Any other combination of mask bits makes the alarm fire on every tick.
- R8: Matching is evaluated only in the cycle where sec_tick is first seen high. A tick held high fires at most once. In pulse mode (the default), irq is high for exactly the one cycle after the clock edge that sampled the rising tick.
- R9: An alarm sets the flag. A read of the status slot returns the flag and clears it at the end of that cycle. If an alarm and a status read fall in the same cycle, the flag stays set.
- R10: Synchronous reset clears all four alarm bytes and the flag, and holds irq low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears flag on status slot) |
| reg_addr | input | ADDR_W | Register slot select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected slot |
| sec_tick | input | 1 | Once-per-second tick; its rising edge triggers evaluation |
| now_sec | input | 8 | Current second, BCD |
| now_min | input | 8 | Current minute, BCD |
| now_hour | input | 8 | Current hour, BCD |
| now_date | input | 8 | Current day of month, BCD |
| irq | output | 1 | Alarm interrupt (pulse or level by parameter) |
| alarm_flag | output | 1 | Alarm flag, also readable at status bit 7 |

## Verification
A table of patterns sets each repeat rate and then offers a current time that either matches every compared field or differs in exactly one of them. This shows that each rate ignores the masked fields and still checks the remaining ones. Mask combinations outside the four named rates must fire on a mismatching time. Current-time bytes with bit 7 or bit 6 set show that only the compared bit range counts. Directed cases cover a tick held high, an alarm that coincides with a status read, write rejection at each range limit, and reset.

// File: rtl/bcd_alarm_pkg.sv
`timescale 1ns/1ps
package bcd_alarm_pkg;

    localparam int unsigned NUM_FIELDS = 4;
    localparam int unsigned SLOT_SEC    = 0;
    localparam int unsigned SLOT_MIN    = 1;
    localparam int unsigned SLOT_HOUR   = 2;
    localparam int unsigned SLOT_DATE   = 3;
    localparam int unsigned SLOT_STATUS = 4;

    localparam logic [7:0] KEEP_WIDE   = 8'h7F;
    localparam logic [7:0] KEEP_NARROW = 8'h3F;

    typedef struct packed {
        logic [7:0] mday;
        logic [7:0] hrs;
        logic [7:0] mins;
        logic [7:0] sec;
    } time_fields_t;

    typedef enum logic [2:0] {
        RPT_MONTHLY,
        RPT_DAILY,
        RPT_HOURLY,
        RPT_MINUTE,
        RPT_SECOND
    } repeat_e;

    function automatic logic [7:0] field_keep(input int unsigned idx);
        return (idx >= SLOT_HOUR) ? KEEP_NARROW : KEEP_WIDE;
    endfunction

    function automatic logic [7:0] field_lo(input int unsigned idx);
        return (idx == SLOT_DATE) ? 8'd1 : 8'd0;
    endfunction

    function automatic logic [7:0] field_hi(input int unsigned idx);
        case (idx)
            SLOT_HOUR: return 8'd23;
            SLOT_DATE: return 8'd31;
            default:   return 8'd59;
        endcase
    endfunction

    function automatic logic [7:0] bcd_value(input logic [7:0] v);
        logic [7:0] tens;
        tens = {4'd0, v[7:4]};
        return (tens * 8'd10) + {4'd0, v[3:0]};
    endfunction

    function automatic logic bcd_in_range(input logic [7:0] v,
                                          input logic [7:0] lo,
                                          input logic [7:0] hi);
        logic [7:0] dec;
        dec = bcd_value(v);
        return (v[3:0] <= 4'd9) && (dec >= lo) && (dec <= hi);
    endfunction

endpackage

// File: rtl/alarm_regfile.sv
`timescale 1ns/1ps
module alarm_regfile
    import bcd_alarm_pkg::*;
#(
    parameter int unsigned ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output time_fields_t      fields
);

    logic [7:0] field_q [NUM_FIELDS];

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        localparam logic [7:0] KEEP = field_keep(i);
        localparam logic [7:0] LO   = field_lo(i);
        localparam logic [7:0] HI   = field_hi(i);

        logic hit;
        logic ok;

        assign hit = we && (addr == ADDR_W'(i));
        assign ok  = bcd_in_range(wdata & KEEP, LO, HI);

        always_ff @(posedge clk) begin
            if (rst) begin
                field_q[i] <= 8'h00;
            end else if (hit && ok) begin
                field_q[i] <= wdata;
            end
        end
    end

    assign fields.sec  = field_q[SLOT_SEC];
    assign fields.mins = field_q[SLOT_MIN];
    assign fields.hrs  = field_q[SLOT_HOUR];
    assign fields.mday = field_q[SLOT_DATE];

endmodule

// File: rtl/alarm_match.sv
`timescale 1ns/1ps
module alarm_match
    import bcd_alarm_pkg::*;
(
    input  time_fields_t alarm_set,
    input  time_fields_t now,
    output logic         match
);

    repeat_e    rate;
    logic [3:0] masks;
    logic       eq_sec, eq_min, eq_hour, eq_date;

    assign masks = {alarm_set.mday[7], alarm_set.hrs[7],
                    alarm_set.mins[7], alarm_set.sec[7]};

    always_comb begin
        case (masks)
            4'b0000: rate = RPT_MONTHLY;
            4'b1000: rate = RPT_DAILY;
            4'b1100: rate = RPT_HOURLY;
            4'b1110: rate = RPT_MINUTE;
            default: rate = RPT_SECOND;
        endcase
    end

    assign eq_sec  = (alarm_set.sec  & KEEP_WIDE)   == (now.sec  & KEEP_WIDE);
    assign eq_min  = (alarm_set.mins & KEEP_WIDE)   == (now.mins & KEEP_WIDE);
    assign eq_hour = (alarm_set.hrs  & KEEP_NARROW) == (now.hrs  & KEEP_NARROW);
    assign eq_date = (alarm_set.mday & KEEP_NARROW) == (now.mday & KEEP_NARROW);

    always_comb begin
        case (rate)
            RPT_MONTHLY: match = eq_date && eq_hour && eq_min && eq_sec;
            RPT_DAILY:   match = eq_hour && eq_min && eq_sec;
            RPT_HOURLY:  match = eq_min && eq_sec;
            RPT_MINUTE:  match = eq_sec;
            default:     match = 1'b1;
        endcase
    end

endmodule

// File: rtl/alarm_irq_gen.sv
`timescale 1ns/1ps
module alarm_irq_gen #(
    parameter bit IRQ_PULSE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic match,
    input  logic rd_clear,
    output logic irq,
    output logic flag
);

    logic tick_q;
    logic hit;
    logic pulse_q;

    assign hit = tick && !tick_q && match;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q  <= 1'b0;
            flag    <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            tick_q  <= tick;
            pulse_q <= hit;
            if (hit) begin
                flag <= 1'b1;
            end else if (rd_clear) begin
                flag <= 1'b0;
            end
        end
    end

    if (IRQ_PULSE) begin : g_pulse
        assign irq = pulse_q;
    end else begin : g_level
        assign irq = flag;
    end

endmodule

// File: rtl/bcd_alarm_cmp.sv
`timescale 1ns/1ps
module bcd_alarm_cmp
    import bcd_alarm_pkg::*;
#(
    parameter int unsigned ADDR_W    = 3,
    parameter bit          IRQ_PULSE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              sec_tick,
    input  logic [7:0]        now_sec,
    input  logic [7:0]        now_min,
    input  logic [7:0]        now_hour,
    input  logic [7:0]        now_date,
    output logic              irq,
    output logic              alarm_flag
);

    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(SLOT_STATUS);

    time_fields_t alarm_regs;
    time_fields_t now_fields;
    logic         match;
    logic         rd_clear;

    assign now_fields = '{mday: now_date, hrs: now_hour, mins: now_min, sec: now_sec};
    assign rd_clear   = reg_re && (reg_addr == STATUS_ADDR);

    alarm_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .fields (alarm_regs)
    );

    alarm_match u_match (
        .alarm_set (alarm_regs),
        .now       (now_fields),
        .match     (match)
    );

    alarm_irq_gen #(.IRQ_PULSE(IRQ_PULSE)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .tick     (sec_tick),
        .match    (match),
        .rd_clear (rd_clear),
        .irq      (irq),
        .flag     (alarm_flag)
    );

    always_comb begin
        case (reg_addr)
            ADDR_W'(SLOT_SEC):    reg_rdata = alarm_regs.sec;
            ADDR_W'(SLOT_MIN):    reg_rdata = alarm_regs.mins;
            ADDR_W'(SLOT_HOUR):   reg_rdata = alarm_regs.hrs;
            ADDR_W'(SLOT_DATE):   reg_rdata = alarm_regs.mday;
            STATUS_ADDR:          reg_rdata = {alarm_flag, 7'b0};
            default:              reg_rdata = 8'hFF;
        endcase
    end

endmodule

// File: rtl/bcd_alarm_chk.sv
`timescale 1ns/1ps
module bcd_alarm_chk
    import bcd_alarm_pkg::*;
#(
    parameter int unsigned ADDR_W    = 3,
    parameter bit          IRQ_PULSE = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic              reg_re,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              sec_tick,
    input logic              irq,
    input logic              alarm_flag,
    input time_fields_t      regs
);

    logic ck_prev;

    always_ff @(posedge clk) begin
        if (rst) ck_prev <= 1'b0;
        else     ck_prev <= sec_tick;
    end

    // R8: a new interrupt only follows a freshly risen tick
    p_irq_after_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(sec_tick && !ck_prev));

    if (IRQ_PULSE) begin : g_pulse_chk
        // R8: pulse lasts one cycle
        p_irq_single_r8: assert property (@(posedge clk) disable iff (rst)
            irq |=> !irq);
    end

    // R9: flag is up whenever an interrupt starts
    p_flag_with_irq_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> alarm_flag);

    // R9: flag only drops after a status read
    p_flag_drop_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(alarm_flag) |-> $past(reg_re && reg_addr == ADDR_W'(SLOT_STATUS)));

    // R1: alarm bytes change only through a write
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> $stable(regs));

    // R2: second values of 60 and above never land
    p_sec_reject_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_W'(SLOT_SEC) && (reg_wdata & 8'h7F) >= 8'h60)
        |=> $stable(regs.sec));

    // R2: hour values above 23 never land
    p_hour_reject_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == ADDR_W'(SLOT_HOUR) && (reg_wdata & 8'h3F) > 8'h23)
        |=> $stable(regs.hrs));

endmodule

bind bcd_alarm_cmp bcd_alarm_chk #(.ADDR_W(ADDR_W), .IRQ_PULSE(IRQ_PULSE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_we     (reg_we),
    .reg_re     (reg_re),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .sec_tick   (sec_tick),
    .irq        (irq),
    .alarm_flag (alarm_flag),
    .regs       (alarm_regs)
);

// File: tb/tb_bcd_alarm_cmp.sv
`timescale 1ns/1ps
module tb_bcd_alarm_cmp;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic       reg_re = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sec_tick = 1'b0;
    logic [7:0] now_sec = 8'h00, now_min = 8'h00, now_hour = 8'h00, now_date = 8'h01;
    logic       irq;
    logic       alarm_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bcd_alarm_cmp dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sec_tick(sec_tick), .now_sec(now_sec), .now_min(now_min),
        .now_hour(now_hour), .now_date(now_date), .irq(irq), .alarm_flag(alarm_flag)
    );

    // {alarm sec,min,hour,date, now sec,min,hour,date, expect fire}
    localparam int NV = 14;
    localparam logic [64:0] VEC [NV] = '{
        {32'h30151221, 32'h30151221, 1'b1},  // R3 full match
        {32'h30151221, 32'h30151222, 1'b0},  // R3 date differs
        {32'h30151221, 32'h30141221, 1'b0},  // R3 minute differs
        {32'h301512A1, 32'h30151205, 1'b1},  // R4 date ignored
        {32'h301512A1, 32'h30151305, 1'b0},  // R4 hour differs
        {32'h301592A1, 32'h30150705, 1'b1},  // R5 hour ignored
        {32'h301592A1, 32'h30160705, 1'b0},  // R5 minute differs
        {32'h309592A1, 32'h30440705, 1'b1},  // R6 minute ignored
        {32'h309592A1, 32'h31440705, 1'b0},  // R6 second differs
        {32'hB09592A1, 32'h01020304, 1'b1},  // R7 all masks
        {32'hB0151221, 32'h01020304, 1'b1},  // R7 second mask only
        {32'h30159221, 32'h01020304, 1'b1},  // R7 hour mask only
        {32'h30151221, 32'hB0155221, 1'b1},  // R3 now bit7 / bit6 ignored
        {32'h30151221, 32'h30151221, 1'b1}   // R3 repeat after clear
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic fire(output logic got);
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        got = irq;
        sec_tick = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic       g;

        do_reset();
        // R10: reset state
        #1 chk("R10 irq after reset", {7'b0, irq}, 8'h00);
        for (int i = 0; i < 4; i++) begin
            rd(3'(i), d);
            chk("R10 field after reset", d, 8'h00);
        end
        rd(3'd4, d);
        chk("R10 status after reset", d, 8'h00);

        // R1: readback and unmapped slots
        wr(3'd0, 8'h45); wr(3'd1, 8'h37); wr(3'd2, 8'h19); wr(3'd3, 8'h28);
        rd(3'd0, d); chk("R1 sec readback", d, 8'h45);
        rd(3'd1, d); chk("R1 min readback", d, 8'h37);
        rd(3'd2, d); chk("R1 hour readback", d, 8'h19);
        rd(3'd3, d); chk("R1 date readback", d, 8'h28);
        rd(3'd5, d); chk("R1 unmapped slot 5", d, 8'hFF);
        rd(3'd7, d); chk("R1 unmapped slot 7", d, 8'hFF);

        // R2: range limits
        wr(3'd0, 8'h60); rd(3'd0, d); chk("R2 sec 60 rejected", d, 8'h45);
        wr(3'd0, 8'h3A); rd(3'd0, d); chk("R2 sec bad digit rejected", d, 8'h45);
        wr(3'd0, 8'hD9); rd(3'd0, d); chk("R2 sec 59 masked accepted", d, 8'hD9);
        wr(3'd1, 8'h5A); rd(3'd1, d); chk("R2 min bad digit rejected", d, 8'h37);
        wr(3'd2, 8'h23); rd(3'd2, d); chk("R2 hour 23 accepted", d, 8'h23);
        wr(3'd2, 8'h24); rd(3'd2, d); chk("R2 hour 24 rejected", d, 8'h23);
        wr(3'd3, 8'h00); rd(3'd3, d); chk("R2 date 0 rejected", d, 8'h28);
        wr(3'd3, 8'h31); rd(3'd3, d); chk("R2 date 31 accepted", d, 8'h31);
        wr(3'd3, 8'h32); rd(3'd3, d); chk("R2 date 32 rejected", d, 8'h31);

        // R3..R7 table: one fire per vector, then status read clears flag
        for (int v = 0; v < NV; v++) begin
            wr(3'd0, VEC[v][64:57]); wr(3'd1, VEC[v][56:49]);
            wr(3'd2, VEC[v][48:41]); wr(3'd3, VEC[v][40:33]);
            now_sec = VEC[v][32:25]; now_min = VEC[v][24:17];
            now_hour = VEC[v][16:9]; now_date = VEC[v][8:1];
            fire(g);
            chk($sformatf("table vector %0d irq", v), {7'b0, g}, {7'b0, VEC[v][0]});
            rd(3'd4, d);
            chk($sformatf("table vector %0d flag", v), d, {VEC[v][0], 7'b0});
        end

        // R8: held tick fires once, one-cycle pulse; no tick means no alarm
        wr(3'd0, 8'hB0); wr(3'd1, 8'h95); wr(3'd2, 8'h92); wr(3'd3, 8'hA1);
        repeat (5) @(negedge clk);
        chk("R8 no tick no irq", {7'b0, irq}, 8'h00);
        rd(3'd4, d); chk("R8 no tick no flag", d, 8'h00);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); chk("R8 held tick first irq", {7'b0, irq}, 8'h01);
        @(negedge clk); chk("R8 pulse ends", {7'b0, irq}, 8'h00);
        repeat (3) @(negedge clk);
        chk("R8 held tick no refire", {7'b0, irq}, 8'h00);
        sec_tick = 1'b0;
        rd(3'd4, d); chk("R8 held tick flag", d, 8'h80);
        rd(3'd4, d); chk("R9 flag cleared by read", d, 8'h00);

        // R9: alarm and status read in the same cycle, set wins
        @(negedge clk);
        reg_re = 1'b1; reg_addr = 3'd4; sec_tick = 1'b1;
        #1 d = reg_rdata;
        chk("R9 read before set", d, 8'h00);
        @(negedge clk);
        reg_re = 1'b0; sec_tick = 1'b0;
        chk("R9 irq on collision", {7'b0, irq}, 8'h01);
        rd(3'd4, d); chk("R9 set wins over clear", d, 8'h80);
        rd(3'd4, d); chk("R9 cleared afterwards", d, 8'h00);

        // R10: reset mid-run with a pending flag
        fire(g);
        do_reset();
        #1 chk("R10 irq low after reset", {7'b0, irq}, 8'h00);
        for (int i = 0; i < 4; i++) begin
            rd(3'(i), d);
            chk("R10 field cleared mid-run", d, 8'h00);
        end
        rd(3'd4, d); chk("R10 flag cleared mid-run", d, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule